// File: doc/BRIEF.md
# Idle Mode Timer Controller

This block holds a free-running 16-bit counter that advances once for each instruction-cycle tick. The counter keeps running while the rest of the chip sits in a low-power idle state. Software has no way to read, load, start or stop the counter. The block ends the idle state when one of five counter taps rolls over. The taps give periods of 4096, 8192, 16384, 32768 and 65536 ticks. Idle also ends on an external wake request or on reset.

Software controls the block through a two-address write port. The configuration address holds a 3-bit tap select and an interrupt enable bit. The command address takes strobes: one enters idle and one clears the pending flag. Each time counter bit 13 changes value, a sticky pending flag is set, whether or not the chip is idle. The interrupt output is the pending flag gated by the enable bit. Because the counter's phase is not under software control, one idle stay lasts between 1 tick and the full selected period.

Top module: `idle_wake_timer`

## Requirements
- R1: After reset, idleActive and irqOut are 0. The tap select is 0 (4096-tick period), the interrupt enable is 0 and the counter is 0.
- R2: The counter advances by one only on a clock edge where cycTick is 1. While idle, with cycTick low and no wake request, idleActive stays 1.
- R3: A write to address 1 with data bit 0 set makes idleActive 1 after that clock edge.
- R4: While idle, a tick that moves the counter's low (12+sel) bits from all ones to zero ends idle. idleActive reads 0 from the following cycle, so when it falls the counter is a multiple of the period.
- R5: Tap-select codes 0 to 4 give periods of 4096, 8192, 16384, 32768 and 65536 ticks. Codes 5 to 7 act as code 4 (65536).
- R6: wakeReq high while idle makes idleActive 0 in the next cycle. wakeReq has no effect while not idle.
- R7: The pending flag is set by a tick that moves the counter's low 13 bits from all ones to zero, which is a change of bit 13. It stays set until a write to address 1 with data bit 1 set clears it.
- R8: Address 0 holds the configuration: data bits [2:0] are the tap select and bit 3 is the interrupt enable. irqOut is 1 exactly when the enable and the pending flag are both 1.
- R9: When a pending set and a pending clear fall on the same edge, the set wins. When idle exit and an enter write fall on the same edge while idle, the exit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycTick | input | 1 | One pulse per instruction cycle |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = configuration, 1 = command |
| regData | input | 4 | Write data |
| wakeReq | input | 1 | External wake request |
| idleActive | output | 1 | High while in the idle state |
| irqOut | output | 1 | Timer interrupt request |

## Verification
Two pairs of events can fall on the same clock edge. One pair is a pending-flag set from the bit-13 change and a software clear of that flag. The other is an idle exit at the tap rollover and a fresh enter-idle write. The bench uses its own behavioural counter to advance to the tick just before each rollover. On that tick it drives the conflicting write. It then judges the result at irqOut (the set must win) and at idleActive (the exit must win). Every other cycle is also compared against the reference model.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;
  localparam int SEL_W     = 3;
  localparam int DATA_W    = SEL_W + 1;
  localparam int EN_BIT    = SEL_W;
  localparam int ENTER_BIT = 0;
  localparam int CLR_BIT   = 1;
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CMD = 1'b1;

  // control -> datapath strobes
  typedef struct packed {
    logic             tick;
    logic [SEL_W-1:0] tapSel;
  } ctlToDp_t;

  // datapath -> control strobes
  typedef struct packed {
    logic tapRoll;
    logic pendEdge;
  } dpToCtl_t;
endpackage

// File: rtl/idle_tmr_dp.sv
module idle_tmr_dp
  import idle_tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_TAP_LOG = 12,
  parameter int NUM_TAPS    = 5,
  parameter int PEND_BIT    = 13
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ctlToDp_t ctl,
  output dpToCtl_t stat
);
  localparam int SEL_MAX = NUM_TAPS - 1;
  localparam logic [SEL_W-1:0] SEL_CLAMP = SEL_W'(SEL_MAX);

  logic [CNT_W-1:0]    cnt;
  logic [NUM_TAPS-1:0] tapFull;
  logic [SEL_W-1:0]    selIdx;
  logic                rollSel;

  // free-running counter, no software access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (ctl.tick) cnt <= cnt + 1'b1;
  end

  // one all-ones detector per tap
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tapFull[i] = &cnt[MIN_TAP_LOG+i-1:0];
  end

  // out-of-range codes fall onto the longest tap
  always_comb selIdx = (ctl.tapSel > SEL_CLAMP) ? SEL_CLAMP : ctl.tapSel;

  always_comb begin
    rollSel = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (selIdx == SEL_W'(i)) rollSel = tapFull[i];
  end

  always_comb begin
    stat.tapRoll  = ctl.tick & rollSel;
    stat.pendEdge = ctl.tick & (&cnt[PEND_BIT-1:0]);
  end
endmodule

// File: rtl/idle_tmr_ctl.sv
module idle_tmr_ctl
  import idle_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycTick,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              wakeReq,
  input  dpToCtl_t          stat,
  output ctlToDp_t          ctl,
  output logic              idleActive,
  output logic              irqOut,
  output logic              pendFlag,
  output logic              enterStb,
  output logic              clrStb
);
  logic [SEL_W-1:0] tapSel;
  logic             irqEn;
  logic             idleQ;
  logic             cfgWr, cmdWr, exitEvt;

  always_comb begin
    cfgWr    = regWr && (regAddr == ADDR_CFG);
    cmdWr    = regWr && (regAddr == ADDR_CMD);
    enterStb = cmdWr && regData[ENTER_BIT];
    clrStb   = cmdWr && regData[CLR_BIT];
    exitEvt  = idleQ && (wakeReq || stat.tapRoll);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tapSel <= '0;
      irqEn  <= 1'b0;
    end else if (cfgWr) begin
      tapSel <= regData[SEL_W-1:0];
      irqEn  <= regData[EN_BIT];
    end
  end

  // exit beats a same-edge enter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idleQ <= 1'b0;
    else if (exitEvt)  idleQ <= 1'b0;
    else if (enterStb) idleQ <= 1'b1;
  end

  // set beats a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pendFlag <= 1'b0;
    else if (stat.pendEdge) pendFlag <= 1'b1;
    else if (clrStb)        pendFlag <= 1'b0;
  end

  always_comb begin
    ctl.tick   = cycTick;
    ctl.tapSel = tapSel;
    idleActive = idleQ;
    irqOut     = irqEn & pendFlag;
  end
endmodule

// File: rtl/idle_wake_timer.sv
module idle_wake_timer
  import idle_tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_TAP_LOG = 12,
  parameter int NUM_TAPS    = 5,
  parameter int PEND_BIT    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycTick,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regData,
  input  logic              wakeReq,
  output logic              idleActive,
  output logic              irqOut
);
  ctlToDp_t ctlBus;
  dpToCtl_t statBus;
  logic     pendFlag, enterStb, clrStb;

  idle_tmr_ctl u_ctl (
    .clk, .rst_n, .cycTick, .regWr, .regAddr, .regData, .wakeReq,
    .stat(statBus), .ctl(ctlBus), .idleActive, .irqOut,
    .pendFlag, .enterStb, .clrStb
  );

  idle_tmr_dp #(
    .CNT_W(CNT_W), .MIN_TAP_LOG(MIN_TAP_LOG),
    .NUM_TAPS(NUM_TAPS), .PEND_BIT(PEND_BIT)
  ) u_dp (
    .clk, .rst_n, .ctl(ctlBus), .stat(statBus)
  );
endmodule

// File: rtl/idle_tmr_chk.sv
module idle_tmr_chk (
  input logic clk,
  input logic rst_n,
  input logic cycTick,
  input logic wakeReq,
  input logic idleActive,
  input logic irqOut,
  input logic pendFlag,
  input logic enterStb,
  input logic clrStb
);
  // R6
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idleActive && wakeReq |=> !idleActive);
  // R6
  wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idleActive && wakeReq && !enterStb |=> !idleActive);
  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idleActive && !wakeReq && !cycTick |=> idleActive);
  // R3
  enter_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idleActive) |-> $past(enterStb));
  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendFlag) |-> $past(cycTick));
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pendFlag && !clrStb |=> pendFlag);
  // R8
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> pendFlag);
endmodule

bind idle_wake_timer idle_tmr_chk chk (
  .clk, .rst_n, .cycTick, .wakeReq, .idleActive, .irqOut,
  .pendFlag(pendFlag), .enterStb(enterStb), .clrStb(clrStb)
);

// File: tb/idle_wake_timer_test.sv
module idle_wake_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, addr = 1'b0, wake = 1'b0;
  logic [3:0] data = '0;
  logic idleActive, irqOut;

  int vectors = 0, misses = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int mCnt = 0, mSel = 0;
  bit mIdle = 0, mPend = 0, mEn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_wake_timer uut (
    .clk, .rst_n, .cycTick(tick), .regWr(wr), .regAddr(addr),
    .regData(data), .wakeReq(wake), .idleActive, .irqOut
  );

  function automatic int period(int s);
    return 4096 << ((s > 4) ? 4 : s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mSel = 0; mIdle = 0; mPend = 0; mEn = 0;
    end else begin
      bit exitE, setE, ent, clr;
      exitE = mIdle && (wake || (tick && (mCnt % period(mSel)) == period(mSel) - 1));
      setE  = tick && (mCnt % 8192) == 8191;
      ent   = wr && addr && data[0];
      clr   = wr && addr && data[1];
      if (wr && !addr) begin mSel = int'(data[2:0]); mEn = data[3]; end
      if (exitE) mIdle = 0; else if (ent) mIdle = 1;
      if (setE) mPend = 1; else if (clr) mPend = 0;
      if (tick) mCnt = (mCnt + 1) % 65536;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    vectors++;
    if (idleActive !== mIdle) begin
      misses++; $display("FAIL R4 idleActive got %0b exp %0b", idleActive, mIdle);
    end
    vectors++;
    if (irqOut !== (mEn && mPend)) begin
      misses++; $display("FAIL R8 irqOut got %0b exp %0b", irqOut, mEn && mPend);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      misses++; $display("FAIL watchdog got %0d cycles exp <= %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got !== exp) begin
      misses++; $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic idleCyc(int n, bit t);
    wr = 0; wake = 0; tick = t;
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(bit a, logic [3:0] d);
    wr = 1; addr = a; data = d; tick = 1; wake = 0;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic runTo(int m, int r);
    wr = 0; wake = 0; tick = 1;
    while ((mCnt % m) != r) @(negedge clk);
  endtask

  task automatic waitFall();
    wr = 0; wake = 0; tick = 1;
    while (idleActive) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 idleActive", idleActive, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 counter", mCnt, 0);

    // R6 wake ignored while not idle
    wake = 1; @(negedge clk); wake = 0;
    check("R6 wake not idle", idleActive, 0);

    // R3 enter, R2 no ticks holds idle, R4 exit at 4096 boundary
    wrReg(1, 4'b0001);
    check("R3 enter", idleActive, 1);
    idleCyc(20, 0);
    check("R2 no tick stays idle", idleActive, 1);
    waitFall();
    check("R4 exit at 4096 boundary", mCnt % 4096, 0);

    // R4 sel 1, then pending with enable off
    wrReg(0, 4'b0001);
    wrReg(1, 4'b0001);
    waitFall();
    check("R4 exit at 8192 boundary", mCnt % 8192, 0);
    check("R8 irq masked", irqOut, 0);
    wrReg(0, 4'b1001);
    check("R7 pending set, R8 irq", irqOut, 1);
    wrReg(1, 4'b0010);
    check("R7 pending cleared", irqOut, 0);

    // R6 wake while idle
    wrReg(1, 4'b0001);
    idleCyc(5, 1);
    wake = 1; @(negedge clk); wake = 0;
    check("R6 wake exit", idleActive, 0);

    // R9 set and clear on the same edge
    runTo(8192, 8191);
    wrReg(1, 4'b0010);
    check("R9 set beats clear", irqOut, 1);
    wrReg(1, 4'b0010);
    check("R7 clear after collision", irqOut, 0);

    // R9 exit and enter on the same edge
    wrReg(0, 4'b1000);
    wrReg(1, 4'b0001);
    runTo(4096, 4095);
    wrReg(1, 4'b0001);
    check("R9 exit beats enter", idleActive, 0);

    // R5 code 7 behaves as 65536
    wrReg(0, 4'b0111);
    wrReg(1, 4'b0001);
    waitFall();
    check("R5 code 7 exit at 65536 boundary", mCnt, 0);

    idleCyc(4, 1);
    finishRun();
  end
endmodule